// File: doc/BRIEF.md
# Digit Sequence Counter with Seven-Segment Output

This block walks through a fixed, endlessly repeating list of decimal digits and presents the digit currently selected, both as a 4-bit binary value and as an active-low seven-segment glyph. The list is fixed when the design is elaborated. It is derived from an identifier parameter of eight decimal digits, and is made of three parts in order. First come the identifier digits, with the most significant nibble first. Next come two zero digits. Last come the identifier digits again, each one raised by one modulo 10. With the default identifier 27273289 the list is 2,7,2,7,3,2,8,9,0,0,3,8,3,8,4,3,9,0. That gives eighteen entries.

The only state is a small position register that counts from 0 to 17. A combinational lookup turns the position into a digit, and a hex decoder turns the digit into segment drive levels. The position moves forward on clock edges where the advance input is high. Reset is synchronous. Elaboration rejects any identifier digit above 9 and any list longer than 32 entries, so the position never needs more than five flip-flops. The caller supplies any slowing of the step rate, for example a one-cycle strobe on the advance input.

Top module: `digit_seq_display`

## Requirements
- R1: At position k the digit output is as follows. For k in 0..7 it is identifier digit k, taken from the most significant nibble of the parameter first. For k of 8 or 9 it is 0. For k in 10..17 it is (identifier digit k-10 + 1) mod 10.
- R2: A clock edge with reset high leaves position 0, so the first identifier digit is shown.
- R3: A clock edge with reset low and advance high moves the position from k to k+1 when k is below 17.
- R4: A clock edge with reset low and advance high at position 17 returns the position to 0.
- R5: A clock edge with reset low and advance low leaves the position, the digit and the segments unchanged.
- R6: The position output is 5 bits wide and never exceeds 17. Any position above 17 returns to 0 on the next edge.
- R7: The segment output is active low, with bit order {g,f,e,d,c,b,a}. The codes for digits 0 to 9 are 40,79,24,30,19,12,02,78,00,10 in hex. Codes 10 to 15 show A,b,C,d,E,F.
- R8: When reset and advance are both high on the same edge, reset wins and the position becomes 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| adv_i | input | 1 | Step to the next list entry on this edge |
| digit_o | output | 4 | Current digit, binary |
| seg_n_o | output | 7 | Segment drive {g,f,e,d,c,b,a}, low lights a segment |
| idx_o | output | 5 | Current list position |

## Verification
Reset and advance can be asserted on the same edge. Wrap and advance also coincide on every step taken from position 17. The bench drives both collisions on purpose: once with a directed reset-plus-advance at mid-list, and many times more through random reset pulses laid over random advance traffic. After each edge the bench model gives priority to reset, then to wrap, then to increment. It compares the position, the digit and the segments one cycle later with the values worked out from that order.

// File: rtl/digit_seq_pkg.sv
package digit_seq_pkg;
  localparam int unsigned DIGIT_W = 4;
  localparam int unsigned SEG_W   = 7;
  localparam int unsigned MAX_POS = 32;

  typedef logic [DIGIT_W-1:0] digit_t;
  typedef logic [SEG_W-1:0]   seg_t;
endpackage

// File: rtl/seq_index_ctr.sv
module seq_index_ctr #(
  parameter int unsigned SEQ_LEN = 18,
  parameter int unsigned IDX_W   = 5
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             adv_i,
  output logic [IDX_W-1:0] idx_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(SEQ_LEN - 1);

  logic [IDX_W-1:0] pos_q;

  // Reset first, then escape from unreachable codes, then a wrapping step.
  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      pos_q <= '0;
    end else if (pos_q > LAST) begin
      pos_q <= '0;
    end else if (adv_i) begin
      pos_q <= (pos_q == LAST) ? '0 : pos_q + 1'b1;
    end
  end

  assign idx_o = pos_q;
endmodule

// File: rtl/seq_digit_lut.sv
module seq_digit_lut
  import digit_seq_pkg::*;
#(
  parameter int unsigned ID_LEN    = 8,
  parameter logic [ID_LEN*DIGIT_W-1:0] ID_BCD = 32'h2727_3289,
  parameter int unsigned PAD_ZEROS = 2,
  parameter int unsigned SEQ_LEN   = 18,
  parameter int unsigned IDX_W     = 5
) (
  input  logic [IDX_W-1:0] idx_i,
  output digit_t           digit_o
);
  localparam int unsigned SLOTS = 1 << IDX_W;

  function automatic digit_t entry_at(int unsigned k);
    digit_t d;
    int unsigned src;
    d = '0;
    if (k < ID_LEN) begin
      d = ID_BCD[(ID_LEN - 1 - k) * DIGIT_W +: DIGIT_W];
    end else if (k >= ID_LEN + PAD_ZEROS && k < SEQ_LEN) begin
      src = k - ID_LEN - PAD_ZEROS;
      d = ID_BCD[(ID_LEN - 1 - src) * DIGIT_W +: DIGIT_W];
      d = (d >= 4'd9) ? 4'd0 : d + 4'd1;
    end
    return d;
  endfunction

  digit_t table_w [SLOTS];

  for (genvar k = 0; k < SLOTS; k++) begin : g_slot
    localparam digit_t VAL = entry_at(k);
    assign table_w[k] = VAL;
  end

  assign digit_o = table_w[idx_i];
endmodule

// File: rtl/hex_seg_decoder.sv
module hex_seg_decoder
  import digit_seq_pkg::*;
(
  input  digit_t code_i,
  output seg_t   seg_n_o
);
  seg_t lit;

  // Active-high glyphs, bit order {g,f,e,d,c,b,a}.
  always_comb begin
    unique case (code_i)
      4'h0: lit = 7'h3F;
      4'h1: lit = 7'h06;
      4'h2: lit = 7'h5B;
      4'h3: lit = 7'h4F;
      4'h4: lit = 7'h66;
      4'h5: lit = 7'h6D;
      4'h6: lit = 7'h7D;
      4'h7: lit = 7'h07;
      4'h8: lit = 7'h7F;
      4'h9: lit = 7'h6F;
      4'hA: lit = 7'h77;
      4'hB: lit = 7'h7C;
      4'hC: lit = 7'h39;
      4'hD: lit = 7'h5E;
      4'hE: lit = 7'h79;
      default: lit = 7'h71;
    endcase
  end

  assign seg_n_o = ~lit;
endmodule

// File: rtl/digit_seq_display.sv
module digit_seq_display
  import digit_seq_pkg::*;
#(
  parameter int unsigned ID_LEN    = 8,
  parameter logic [ID_LEN*DIGIT_W-1:0] ID_BCD = 32'h2727_3289,
  parameter int unsigned PAD_ZEROS = 2,
  localparam int unsigned SEQ_LEN  = 2 * ID_LEN + PAD_ZEROS,
  localparam int unsigned IDX_W    = (SEQ_LEN > 1) ? $clog2(SEQ_LEN) : 1
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             adv_i,
  output logic [3:0]       digit_o,
  output logic [6:0]       seg_n_o,
  output logic [IDX_W-1:0] idx_o
);
  if (SEQ_LEN > MAX_POS) begin : g_len_bad
    $error("digit_seq_display: list of %0d entries exceeds %0d", SEQ_LEN, MAX_POS);
  end

  for (genvar i = 0; i < ID_LEN; i++) begin : g_id_chk
    if (ID_BCD[i*DIGIT_W +: DIGIT_W] > 9) begin : g_bad
      $error("digit_seq_display: identifier nibble %0d is not decimal", i);
    end
  end

  logic [IDX_W-1:0] pos_w;
  digit_t           digit_w;

  seq_index_ctr #(
    .SEQ_LEN(SEQ_LEN),
    .IDX_W  (IDX_W)
  ) i_ctr (
    .clk_i(clk_i),
    .rst_i(rst_i),
    .adv_i(adv_i),
    .idx_o(pos_w)
  );

  seq_digit_lut #(
    .ID_LEN   (ID_LEN),
    .ID_BCD   (ID_BCD),
    .PAD_ZEROS(PAD_ZEROS),
    .SEQ_LEN  (SEQ_LEN),
    .IDX_W    (IDX_W)
  ) i_lut (
    .idx_i  (pos_w),
    .digit_o(digit_w)
  );

  hex_seg_decoder i_seg (
    .code_i (digit_w),
    .seg_n_o(seg_n_o)
  );

  assign idx_o   = pos_w;
  assign digit_o = digit_w;
endmodule

// File: rtl/digit_seq_display_chk.sv
module digit_seq_display_chk #(
  parameter int unsigned SEQ_LEN = 18,
  parameter int unsigned IDX_W   = 5
) (
  input logic             clk_i,
  input logic             rst_i,
  input logic             adv_i,
  input logic [3:0]       digit_o,
  input logic [6:0]       seg_n_o,
  input logic [IDX_W-1:0] idx_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(SEQ_LEN - 1);

  // R2
  reset_home_chk: assert property (@(posedge clk_i)
    rst_i |=> (idx_o == '0));

  // R3
  step_up_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (adv_i && idx_o < LAST) |=> (idx_o == $past(idx_o) + 1'b1));

  // R4
  wrap_home_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (adv_i && idx_o == LAST) |=> (idx_o == '0));

  // R5
  hold_still_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !adv_i |=> ($stable(idx_o) && $stable(digit_o) && $stable(seg_n_o)));

  // R6
  pos_range_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    idx_o <= LAST);

  // R1
  decimal_only_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    digit_o <= 4'd9);

  // R7
  glyph_lit_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    seg_n_o != 7'h7F);
endmodule

bind digit_seq_display digit_seq_display_chk #(
  .SEQ_LEN(SEQ_LEN),
  .IDX_W  (IDX_W)
) i_chk (
  .clk_i  (clk_i),
  .rst_i  (rst_i),
  .adv_i  (adv_i),
  .digit_o(digit_o),
  .seg_n_o(seg_n_o),
  .idx_o  (idx_o)
);

// File: tb/test_digit_seq_display.sv
module test_digit_seq_display;
  localparam int unsigned ID_LEN = 8;
  localparam logic [31:0] ID_BCD = 32'h2727_3289;
  localparam int unsigned SEQ_LEN = 18;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       adv = 1'b0;
  logic [3:0] digit;
  logic [6:0] seg_n;
  logic [4:0] idx;

  int checks = 0;
  int fails  = 0;
  int exp_pos = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  digit_seq_display #(.ID_LEN(ID_LEN), .ID_BCD(ID_BCD)) i_digit_seq_display (
    .clk_i(clk), .rst_i(rst), .adv_i(adv),
    .digit_o(digit), .seg_n_o(seg_n), .idx_o(idx)
  );

  function automatic int exp_digit(int k);
    int d;
    if (k < 8) return int'(ID_BCD[(7 - k) * 4 +: 4]);
    if (k < 10) return 0;
    d = int'(ID_BCD[(7 - (k - 10)) * 4 +: 4]);
    return (d + 1) % 10;
  endfunction

  function automatic logic [6:0] exp_seg(int d);
    case (d)
      0: return 7'h40;  1: return 7'h79;  2: return 7'h24;  3: return 7'h30;
      4: return 7'h19;  5: return 7'h12;  6: return 7'h02;  7: return 7'h78;
      8: return 7'h00;  default: return 7'h10;
    endcase
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d pos=%0d", tag, act, exp, exp_pos);
    end
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  // Apply inputs, let one edge pass, update model, compare between edges.
  task automatic step(input logic r, input logic a);
    string tag;
    rst = r;
    adv = a;
    @(posedge clk);
    if (r) begin
      tag = a ? "R8" : "R2";
      exp_pos = 0;
    end else if (a) begin
      if (exp_pos == SEQ_LEN - 1) begin tag = "R4"; exp_pos = 0; end
      else begin tag = "R3"; exp_pos++; end
    end else begin
      tag = "R5";
    end
    @(negedge clk);
    check(tag, int'(idx), exp_pos);
    check("R1", int'(digit), exp_digit(exp_pos));
    check("R7", int'(seg_n), int'(exp_seg(exp_digit(exp_pos))));
    check("R6", int'(idx <= 5'd17), 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7321));
    step(1'b1, 1'b0);                                    // R2
    for (int i = 0; i < 21; i++) step(1'b0, 1'b1);       // R1 R3 R4 full pass
    for (int i = 0; i < 4; i++) step(1'b0, 1'b0);        // R5
    step(1'b1, 1'b1);                                    // R8
    for (int i = 0; i < 17; i++) step(1'b0, 1'b1);       // reach 17
    step(1'b1, 1'b1);                                    // R8 at the wrap point
    for (int i = 0; i < 3000; i++) begin
      logic r = (($urandom % 32) == 0);
      logic a = ($urandom % 2) == 1;
      step(r, a);
    end
    done = 1'b1;
    summary();
    $finish;
  end
endmodule